// File: doc/BRIEF.md
# Stacked Register Frame Mapper

The mapper translates 7-bit logical general-register numbers into physical indices of a 128-entry register file. Logical numbers below 32 are global and pass straight through; number 0 is the hardwired-zero register. The 96 registers above the globals form a stacked region. An allocate command sizes the current frame from three counts (input, local and output registers). Stacked names that fall outside the frame are flagged as errors. Software that never allocates a frame can still use every global register.

The input and local registers of the frame together form a rotating region. Each rotate-step pulse shifts the logical names in that region down by one, so a loop body can address a moving window of values without copying them. The output registers are never rotated. The block serves several lookup lanes per cycle. The last lane is the destination lane: its write enable is suppressed for register 0 and for out-of-frame names.

Lookups are purely combinational and have no handshake. Every lane is resolved in the same cycle its logical number is presented, so there is no back-pressure. Allocate and rotate commands are single-cycle control pulses that update registered frame state at the clock edge.

Top module: `regframe_mapper`

## Requirements
- R1: A logical number below 32 maps to the same physical index and never raises the out-of-frame flag.
- R2: Logical number 0 raises the lane's zero flag, and a write request on the destination lane (the last lane) addressing it produces no write enable.
- R3: An allocate command whose counts sum to at most 96 takes effect at the next clock edge. It sets the frame size to in+local+out and the rotating size to in+local, and it clears the rotation offset. Lookups in the cycle of the command still use the old frame.
- R4: An allocate command whose counts sum to more than 96 is ignored, and the frame, rotating size and rotation offset are all kept.
- R5: A stacked logical number L (32..127) with L−32 below the frame size but at or above the rotating size maps to physical index L.
- R6: For a stacked L with k = L−32 below the rotating size S, the physical index is 32 + ((k + rot) mod S). A rotate step sets rot to (rot − 1) mod S, so logical L then names the register that L−1 named before, and the lowest rotating name takes the one that the highest name held.
- R7: A rotate step is ignored when the rotating size is 0, and also when an allocate command is asserted in the same cycle (the allocate wins).
- R8: A stacked L with L−32 at or above the frame size raises the out-of-frame flag and drives physical index 0. After reset, every stacked name is out of frame.
- R9: The destination write enable equals the write request masked by the destination lane's zero flag and out-of-frame flag.
- R10: Reset sets the frame size, the rotating size and the rotation offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| log_i | input | NLANE*7 | Logical register number per lane, lane 0 in the low bits |
| phys_o | output | NLANE*7 | Physical index per lane |
| oof_o | output | NLANE | Out-of-frame flag per lane |
| zero_o | output | NLANE | Lane addresses the hardwired-zero register |
| dst_we_i | input | 1 | Write request for the destination lane |
| dst_we_o | output | 1 | Write enable after masking |
| alloc_i | input | 1 | Allocate-frame command pulse |
| alloc_in_i | input | 7 | Input register count |
| alloc_loc_i | input | 7 | Local register count |
| alloc_out_i | input | 7 | Output register count |
| rot_step_i | input | 1 | Rotate-step pulse |

## Verification
Lane results are combinational, so the bench settles them 1 ns after it changes a logical number and samples in that same cycle. Allocate and rotate commands are driven at a falling edge and then removed at the next falling edge. Their effect is therefore checked one rising edge after they are applied. The same-cycle rule of R3 is checked separately: the lookup is sampled while the allocate is still asserted, before the rising edge, and must still show the old frame.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
  localparam int unsigned RF_LOG_W = 7;
  localparam int unsigned RF_NPHYS = 128;
  localparam int unsigned RF_NGLOB = 32;

  typedef logic [RF_LOG_W-1:0] rnum_t;

  // Current frame: total size, rotating size, rotation offset
  typedef struct packed {
    rnum_t size;
    rnum_t rsz;
    rnum_t rot;
  } frame_t;
endpackage

// File: rtl/regframe_state.sv
module regframe_state
  import regframe_pkg::*;
#(
  parameter int unsigned NSTK = RF_NPHYS - RF_NGLOB
) (
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   alloc_i,
  input  rnum_t  cnt_in_i,
  input  rnum_t  cnt_loc_i,
  input  rnum_t  cnt_out_i,
  input  logic   step_i,
  output frame_t frm_o
);
  localparam int unsigned SW = RF_LOG_W + 2;
  localparam logic [SW-1:0] NSTK_W = SW'(NSTK);

  logic [SW-1:0] total;
  logic [SW-1:0] rot_total;
  logic          fits;
  frame_t        frm_q;

  always_comb begin
    rot_total = SW'(cnt_in_i) + SW'(cnt_loc_i);
    total     = rot_total + SW'(cnt_out_i);
    fits      = (total <= NSTK_W);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      frm_q <= '0;
    end else if (alloc_i) begin
      if (fits) begin
        frm_q.size <= rnum_t'(total);
        frm_q.rsz  <= rnum_t'(rot_total);
        frm_q.rot  <= '0;
      end
    end else if (step_i && (frm_q.rsz != '0)) begin
      frm_q.rot <= (frm_q.rot == '0) ? frm_q.rsz - rnum_t'(1) : frm_q.rot - rnum_t'(1);
    end
  end

  assign frm_o = frm_q;
endmodule

// File: rtl/regframe_lane.sv
module regframe_lane
  import regframe_pkg::*;
#(
  parameter int unsigned NGLOB = RF_NGLOB
) (
  input  rnum_t  lg_i,
  input  frame_t frm_i,
  output rnum_t  phys_o,
  output logic   oof_o,
  output logic   zero_o
);
  localparam rnum_t GBASE = rnum_t'(NGLOB);
  localparam int unsigned WW = RF_LOG_W + 1;

  logic          is_glob;
  rnum_t         off;
  logic [WW-1:0] spin;
  logic [WW-1:0] wrapped;
  rnum_t         idx;

  always_comb begin
    is_glob = (lg_i < GBASE);
    off     = lg_i - GBASE;
    spin    = WW'(off) + WW'(frm_i.rot);
    wrapped = (spin >= WW'(frm_i.rsz)) ? spin - WW'(frm_i.rsz) : spin;
    idx     = (off < frm_i.rsz) ? rnum_t'(wrapped) : off;
    oof_o   = !is_glob && (off >= frm_i.size);
    zero_o  = (lg_i == '0);
    if (is_glob)    phys_o = lg_i;
    else if (oof_o) phys_o = '0;
    else            phys_o = idx + GBASE;
  end
endmodule

// File: rtl/regframe_mapper.sv
module regframe_mapper
  import regframe_pkg::*;
#(
  parameter int unsigned NLANE = 3,
  parameter int unsigned NGLOB = RF_NGLOB
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic [NLANE*RF_LOG_W-1:0] log_i,
  output logic [NLANE*RF_LOG_W-1:0] phys_o,
  output logic [NLANE-1:0]          oof_o,
  output logic [NLANE-1:0]          zero_o,
  input  logic                      dst_we_i,
  output logic                      dst_we_o,
  input  logic                      alloc_i,
  input  logic [RF_LOG_W-1:0]       alloc_in_i,
  input  logic [RF_LOG_W-1:0]       alloc_loc_i,
  input  logic [RF_LOG_W-1:0]       alloc_out_i,
  input  logic                      rot_step_i
);
  localparam int unsigned NSTK = RF_NPHYS - NGLOB;
  localparam int unsigned DST  = NLANE - 1;

  frame_t frm;

  regframe_state #(.NSTK(NSTK)) state_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .alloc_i   (alloc_i),
    .cnt_in_i  (alloc_in_i),
    .cnt_loc_i (alloc_loc_i),
    .cnt_out_i (alloc_out_i),
    .step_i    (rot_step_i),
    .frm_o     (frm)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    regframe_lane #(.NGLOB(NGLOB)) lane_i (
      .lg_i   (log_i[g*RF_LOG_W +: RF_LOG_W]),
      .frm_i  (frm),
      .phys_o (phys_o[g*RF_LOG_W +: RF_LOG_W]),
      .oof_o  (oof_o[g]),
      .zero_o (zero_o[g])
    );
  end

  assign dst_we_o = dst_we_i & ~zero_o[DST] & ~oof_o[DST];
endmodule

// File: rtl/regframe_mapper_chk.sv
module regframe_mapper_chk
  import regframe_pkg::*;
#(
  parameter int unsigned NLANE = 3,
  parameter int unsigned NGLOB = RF_NGLOB
) (
  input logic                      clk_i,
  input logic                      rst_n_i,
  input logic [NLANE*RF_LOG_W-1:0] log_i,
  input logic [NLANE*RF_LOG_W-1:0] phys_o,
  input logic [NLANE-1:0]          oof_o,
  input logic [NLANE-1:0]          zero_o,
  input logic                      dst_we_i,
  input logic                      dst_we_o,
  input logic                      alloc_i,
  input logic [RF_LOG_W-1:0]       alloc_in_i,
  input logic [RF_LOG_W-1:0]       alloc_loc_i,
  input logic [RF_LOG_W-1:0]       alloc_out_i,
  input logic                      rot_step_i,
  input frame_t                    frm
);
  localparam int unsigned SW = RF_LOG_W + 2;
  localparam logic [SW-1:0] NSTK_W = SW'(RF_NPHYS - NGLOB);
  localparam int unsigned DST = NLANE - 1;

  logic [SW-1:0] asum;
  assign asum = SW'(alloc_in_i) + SW'(alloc_loc_i) + SW'(alloc_out_i);

  // R1
  glob_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (log_i[RF_LOG_W-1:0] < rnum_t'(NGLOB)) |->
      (phys_o[RF_LOG_W-1:0] == log_i[RF_LOG_W-1:0]) && !oof_o[0]);

  // R3
  alloc_take_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (alloc_i && asum <= NSTK_W) |=>
      (frm.size == rnum_t'($past(asum))) && (frm.rot == '0));

  // R4
  alloc_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (alloc_i && asum > NSTK_W) |=> $stable(frm));

  // R6
  rot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rot_step_i && !alloc_i && frm.rsz != '0) |=>
      frm.rot == (($past(frm.rot) == '0) ? $past(frm.rsz) - rnum_t'(1)
                                         : $past(frm.rot) - rnum_t'(1)));

  // R6
  rot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (frm.rsz == '0) ? (frm.rot == '0) : (frm.rot < frm.rsz));

  // R7
  rot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rot_step_i && !alloc_i && frm.rsz == '0) |=> $stable(frm.rot));

  // R8
  oof_phys_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    oof_o[0] |-> (phys_o[RF_LOG_W-1:0] == '0));

  // R9
  wen_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    dst_we_o |-> (dst_we_i && !zero_o[DST] && !oof_o[DST]));
endmodule

bind regframe_mapper regframe_mapper_chk #(.NLANE(NLANE), .NGLOB(NGLOB)) chk_i (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .log_i       (log_i),
  .phys_o      (phys_o),
  .oof_o       (oof_o),
  .zero_o      (zero_o),
  .dst_we_i    (dst_we_i),
  .dst_we_o    (dst_we_o),
  .alloc_i     (alloc_i),
  .alloc_in_i  (alloc_in_i),
  .alloc_loc_i (alloc_loc_i),
  .alloc_out_i (alloc_out_i),
  .rot_step_i  (rot_step_i),
  .frm         (frm)
);

// File: tb/regframe_mapper_tb_top.sv
module regframe_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] log_v = '0;
  logic [20:0] phys;
  logic [2:0]  oof, zero;
  logic        we_in = 1'b0, we_out;
  logic        alloc = 1'b0, step = 1'b0;
  logic [6:0]  c_in = '0, c_loc = '0, c_out = '0;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  regframe_mapper dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .log_i(log_v), .phys_o(phys), .oof_o(oof),
    .zero_o(zero), .dst_we_i(we_in), .dst_we_o(we_out), .alloc_i(alloc),
    .alloc_in_i(c_in), .alloc_loc_i(c_loc), .alloc_out_i(c_out), .rot_step_i(step)
  );

  typedef struct packed {
    logic       al;
    logic [6:0] ni, nl, no;
    logic       st;
    logic [6:0] lg;
    logic [6:0] ph;
    logic       of;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 7'd4, 7'd4, 7'd2,  1'b0, 7'd40,  7'd40,  1'b0}, // R3 R5
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b0, 7'd42,  7'd0,   1'b1}, // R8
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b0, 7'd33,  7'd33,  1'b0}, // R6 rot 0
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd34,  7'd33,  1'b0}, // R6 rot 7
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd32,  7'd38,  1'b0}, // R6 rot 6
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b0, 7'd39,  7'd37,  1'b0}, // R6 wrap
    '{1'b1, 7'd8, 7'd0, 7'd0,  1'b1, 7'd39,  7'd39,  1'b0}, // R7 alloc wins
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b0, 7'd40,  7'd0,   1'b1}, // R8
    '{1'b1, 7'd50, 7'd40, 7'd10, 1'b0, 7'd40, 7'd0,  1'b1}, // R4 rejected
    '{1'b1, 7'd0, 7'd0, 7'd96, 1'b0, 7'd127, 7'd127, 1'b0}, // R3 R5 full
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd32,  7'd32,  1'b0}, // R7 rsz 0
    '{1'b1, 7'd0, 7'd3, 7'd0,  1'b0, 7'd34,  7'd34,  1'b0}, // R3
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd32,  7'd34,  1'b0}, // R6 rot 2
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd32,  7'd33,  1'b0}, // R6 rot 1
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b1, 7'd32,  7'd32,  1'b0}, // R6 rot 0
    '{1'b0, 7'd0, 7'd0, 7'd0,  1'b0, 7'd5,   7'd5,   1'b0}  // R1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic a, input logic [6:0] i, input logic [6:0] l,
                     input logic [6:0] o, input logic s);
    @(negedge clk);
    alloc = a; c_in = i; c_loc = l; c_out = o; step = s;
    @(negedge clk);
    alloc = 1'b0; step = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 R8: reset frame is empty, every stacked name out of frame
    log_v = {7'd1, 7'd1, 7'd32}; #1;
    chk("R10", {7'd0, oof[0]}, 8'd1);
    chk("R8",  {1'b0, phys[6:0]}, 8'd0);
    // R1 global with empty frame
    log_v = {7'd1, 7'd1, 7'd31}; #1;
    chk("R1", {oof[0], phys[6:0]}, {1'b0, 7'd31});

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].al || TBL[k].st)
        cmd(TBL[k].al, TBL[k].ni, TBL[k].nl, TBL[k].no, TBL[k].st);
      log_v[6:0] = TBL[k].lg; #1;
      chk($sformatf("R6 vec %0d phys", k), {1'b0, phys[6:0]}, {1'b0, TBL[k].ph});
      chk($sformatf("R8 vec %0d oof", k), {7'd0, oof[0]}, {7'd0, TBL[k].of});
    end

    // Frame now: size 3, rsz 3, rot 0
    // R2: register 0 zero flag, write suppressed on destination lane
    @(negedge clk);
    log_v = {7'd0, 7'd0, 7'd0}; we_in = 1'b1; #1;
    chk("R2 zero", {7'd0, zero[2]}, 8'd1);
    chk("R2 we", {7'd0, we_out}, 8'd0);
    // R9: in-frame stacked destination writes, out-of-frame does not
    log_v[20:14] = 7'd33; #1;
    chk("R9 in", {7'd0, we_out}, 8'd1);
    log_v[20:14] = 7'd35; #1;
    chk("R9 oof", {7'd0, we_out}, 8'd0);
    we_in = 1'b0; #1;
    log_v[20:14] = 7'd33; #1;
    chk("R9 noreq", {7'd0, we_out}, 8'd0);

    // R3: same-cycle lookup uses the old frame
    @(negedge clk);
    alloc = 1'b1; c_in = 7'd0; c_loc = 7'd0; c_out = 7'd10; log_v[6:0] = 7'd40; #1;
    chk("R3 old", {7'd0, oof[0]}, 8'd1);
    @(negedge clk);
    alloc = 1'b0; #1;
    chk("R3 new", {oof[0], phys[6:0]}, {1'b0, 7'd40});

    // R10: mid-run reset clears the frame
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R10 rst", {7'd0, oof[0]}, 8'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule